// File: doc/BRIEF.md
# DRAM Cycle Type Classifier

This block is a passive observer for an asynchronous EDO DRAM bus. It oversamples the row strobe, the two byte-lane column strobes, the write enable and the output enable on a fast system clock. It never drives the bus. It finds edges by comparing each sample with the one before it. From the order of those edges it decides which kind of cycle the memory controller has just run, and it reports that cycle as a four-bit code, qualified by a one-cycle valid pulse, together with a two-bit byte-lane mask.

The block tells accesses apart by what happens to the write and output enables around each column pulse. It tells refreshes apart by whether a column strobe was already low when the row strobe fell. It also counts how many samples the row strobe stayed high between two row cycles. When that precharge gap is shorter than the programmable `minPrecharge` value, it raises a one-cycle violation flag. Long row-low periods are counted too, so that a column-before-row refresh held long enough is reported as a self-refresh entry.

Top module: `dram_cycle_classifier`

## Requirements
- R1: After reset, `evtValid` and `violation` are low and `evtCode` is 0 (standby). Whenever `evtValid` is high, `evtCode` is never 0.
- R2: A row strobe low period during which no column strobe goes low is reported with code 9 and lane mask 00 when the row strobe rises.
- R3: If a column strobe was already low in the sample before the row strobe fell, and that strobe was not held over from an access, the cycle is a column-before-row refresh. It is reported with code 10 and lane mask 00 when the row strobe rises, provided the row strobe stayed low for fewer than `SELF_LIMIT` samples.
- R4: The same column-before-row refresh with the row strobe low for `SELF_LIMIT` samples or more is reported with code 12 (self-refresh) and lane mask 00.
- R5: A column pulse with write enable high throughout is a read. It is reported with code 1 when the last column strobe rises.
- R6: A column pulse whose write enable is already low in the sample where the first column strobe falls is an early write, code 2.
- R7: A column pulse in which write enable falls after the column strobe, with output enable never low before that, is a late write, code 3.
- R8: A column pulse in which output enable is low with write enable high, and write enable then falls within the same pulse, is a read-write, code 4.
- R9: The lane mask of an access is the OR, over all samples of its column pulse, of bit 0 = low-byte column strobe low and bit 1 = high-byte column strobe low. Staggered strobes therefore report 11.
- R10: Within one row-low period, the second and every later column pulse is a page access. Its code is the single-access code plus 4, giving 5 for read, 6 for early write, 7 for late write and 8 for read-write.
- R11: If the row strobe rises while a column strobe is still low, the access is reported at that rise. A following row low period that starts while that column strobe is still held is a hidden refresh, reported with code 11 and lane mask 00 when the row strobe rises again.
- R12: On a row strobe fall, `violation` pulses for one cycle, two clocks after the fall is driven, when the number of high samples since the previous row rise is less than `minPrecharge`. It stays low for the first fall after reset.
- R13: `evtValid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rasN | input | 1 | Row strobe, active low |
| caslN | input | 1 | Low-byte column strobe, active low |
| cashN | input | 1 | High-byte column strobe, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| minPrecharge | input | PRE_W | Minimum row-high samples between row cycles |
| evtValid | output | 1 | One-cycle pulse marking a classified cycle |
| evtCode | output | 4 | Cycle code (0 standby, 1..12 as in the requirements) |
| evtLanes | output | 2 | Byte lanes touched by an access, 00 for refreshes |
| violation | output | 1 | One-cycle precharge-too-short flag |

## Verification
The bench builds the block with `SELF_LIMIT` set to 40 samples instead of the 100 us default of 25000. This lets self-refresh entries and just-short column-before-row refreshes both occur within a short run. It keeps `PRE_W` at 8 and switches `minPrecharge` from 6 to 3 halfway through. Random row gaps of one to nine samples then land on both sides of the threshold, including the exact boundary, where no flag is expected.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  localparam int LANES = 2;

  typedef enum logic [3:0] {
    CYC_STANDBY   = 4'd0,
    CYC_READ      = 4'd1,
    CYC_EWRITE    = 4'd2,
    CYC_LWRITE    = 4'd3,
    CYC_RDWR      = 4'd4,
    CYC_PG_READ   = 4'd5,
    CYC_PG_EWRITE = 4'd6,
    CYC_PG_LWRITE = 4'd7,
    CYC_PG_RDWR   = 4'd8,
    CYC_RASONLY   = 4'd9,
    CYC_CBR       = 4'd10,
    CYC_HIDDEN    = 4'd11,
    CYC_SELFREF   = 4'd12
  } cycCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     emit;
    cycCode_e code;
    logic     useLanes;
    logic     checkPre;
  } ctrlStrobe_t;

  // one registered sample of the bus control lines
  typedef struct packed {
    logic rasN;
    logic caslN;
    logic cashN;
    logic weN;
    logic oeN;
  } busSample_t;

endpackage

// File: rtl/dcc_datapath.sv
module dcc_datapath
  import dcc_pkg::*;
#(
  parameter int PRE_W      = 8,
  parameter int SELF_LIMIT = 25000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rasN,
  input  logic             caslN,
  input  logic             cashN,
  input  logic             weN,
  input  logic             oeN,
  input  logic [PRE_W-1:0] minPrecharge,
  input  ctrlStrobe_t      stb,
  output busSample_t       curS,
  output logic             prvRasN,
  output logic [LANES-1:0] prvCasLow,
  output logic             selfLong,
  output logic             evtValid,
  output logic [3:0]       evtCode,
  output logic [LANES-1:0] evtLanes,
  output logic             violation
);

  localparam int LOW_W = $clog2(SELF_LIMIT + 1);
  localparam logic [LOW_W-1:0] LOW_MAX = LOW_W'(SELF_LIMIT);

  logic [PRE_W-1:0] preCnt;
  logic [LOW_W-1:0] lowCnt;
  logic [LANES-1:0] curLow;
  logic [LANES-1:0] laneAcc;
  logic             casStartD;
  logic             preShort;

  // sample the bus and keep the previous sample for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curS      <= '1;
      prvRasN   <= 1'b1;
      prvCasLow <= '0;
    end else begin
      curS      <= '{rasN: rasN, caslN: caslN, cashN: cashN, weN: weN, oeN: oeN};
      prvRasN   <= curS.rasN;
      prvCasLow <= curLow;
    end
  end

  assign curLow    = {~curS.cashN, ~curS.caslN};
  assign casStartD = (curLow != '0) && (prvCasLow == '0);

  // row-high sample counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (!curS.rasN)      preCnt <= '0;
    else if (preCnt != '1)    preCnt <= preCnt + 1'b1;
  end

  // row-low sample counter, saturating at the self-refresh limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lowCnt <= '0;
    else if (curS.rasN)       lowCnt <= '0;
    else if (lowCnt < LOW_MAX) lowCnt <= lowCnt + 1'b1;
  end

  assign selfLong = (lowCnt >= LOW_MAX);
  assign preShort = (preCnt < minPrecharge);

  // per-lane accumulation over one column pulse
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          laneAcc[g] <= 1'b0;
      else if (casStartD) laneAcc[g] <= curLow[g];
      else                laneAcc[g] <= laneAcc[g] | curLow[g];
    end
  end

  // event and violation outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtValid  <= 1'b0;
      evtCode   <= 4'(CYC_STANDBY);
      evtLanes  <= '0;
      violation <= 1'b0;
    end else begin
      evtValid  <= stb.emit;
      evtCode   <= stb.emit ? 4'(stb.code) : 4'(CYC_STANDBY);
      evtLanes  <= (stb.emit && stb.useLanes) ? (laneAcc | curLow) : '0;
      violation <= stb.checkPre && preShort;
    end
  end

  // R13
  no_double_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |=> !evtValid);

  // R1
  valid_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtCode != 4'(CYC_STANDBY)));

  // R9
  access_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtCode <= 4'(CYC_PG_RDWR)) |-> (evtLanes != '0));

  // R2
  refresh_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtCode >= 4'(CYC_RASONLY)) |-> (evtLanes == '0));

  // R12
  viol_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> !violation);

endmodule

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
  import dcc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  busSample_t       curS,
  input  logic             prvRasN,
  input  logic [LANES-1:0] prvCasLow,
  input  logic             selfLong,
  output ctrlStrobe_t      stb
);

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_CBR, ST_HIDDEN} state_e;

  state_e state, nextState;
  logic   casHeld, anyPulse, early, weFell, oeSeen, seenRas;
  logic   curAny, prvAny, rasFall, rasRise, casStart, casEnd;

  assign curAny   = ~curS.caslN | ~curS.cashN;
  assign prvAny   = prvCasLow != '0;
  assign rasFall  = prvRasN & ~curS.rasN;
  assign rasRise  = ~prvRasN & curS.rasN;
  assign casStart = curAny & ~prvAny;
  assign casEnd   = prvAny & ~curAny;

  function automatic cycCode_e accessCode(logic pg, logic e, logic wf, logic os);
    logic [3:0] b;
    if (e)       b = 4'(CYC_EWRITE);
    else if (wf) b = os ? 4'(CYC_RDWR) : 4'(CYC_LWRITE);
    else         b = 4'(CYC_READ);
    if (pg) b = b + 4'd4;
    return cycCode_e'(b);
  endfunction

  always_comb begin
    stb       = '{emit: 1'b0, code: CYC_STANDBY, useLanes: 1'b0, checkPre: 1'b0};
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (rasFall) begin
          stb.checkPre = seenRas;
          if (prvAny) nextState = casHeld ? ST_HIDDEN : ST_CBR;
          else        nextState = ST_ACCESS;
        end
      end
      ST_ACCESS: begin
        if (rasRise && curAny) begin
          stb.emit     = 1'b1;
          stb.useLanes = 1'b1;
          stb.code     = accessCode(anyPulse, early, weFell, oeSeen);
        end else if (casEnd) begin
          stb.emit     = 1'b1;
          stb.useLanes = 1'b1;
          stb.code     = accessCode(anyPulse, early, weFell, oeSeen);
        end else if (rasRise && !anyPulse) begin
          stb.emit = 1'b1;
          stb.code = CYC_RASONLY;
        end
        if (rasRise) nextState = ST_IDLE;
      end
      ST_CBR: begin
        if (rasRise) begin
          stb.emit  = 1'b1;
          stb.code  = selfLong ? CYC_SELFREF : CYC_CBR;
          nextState = ST_IDLE;
        end
      end
      default: begin
        if (rasRise) begin
          stb.emit  = 1'b1;
          stb.code  = CYC_HIDDEN;
          nextState = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      casHeld  <= 1'b0;
      anyPulse <= 1'b0;
      seenRas  <= 1'b0;
    end else begin
      state <= nextState;
      if (rasRise) seenRas <= 1'b1;
      if (state == ST_IDLE && rasFall)        anyPulse <= 1'b0;
      else if (state == ST_ACCESS && casEnd)  anyPulse <= 1'b1;
      case (state)
        ST_IDLE:   if (casEnd) casHeld <= 1'b0;
        ST_ACCESS: if (rasRise) casHeld <= curAny;
        ST_CBR:    if (rasRise) casHeld <= 1'b0;
        default:   if (rasRise) casHeld <= 1'b1;
      endcase
    end
  end

  // attributes of the current column pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      early  <= 1'b0;
      weFell <= 1'b0;
      oeSeen <= 1'b0;
    end else if (casStart) begin
      early  <= ~curS.weN;
      weFell <= 1'b0;
      oeSeen <= ~curS.oeN & curS.weN;
    end else if (curAny) begin
      if (~curS.weN && !early)                oeSeen <= oeSeen;
      if (~curS.weN && !early)                weFell <= 1'b1;
      if (~curS.oeN && curS.weN && !weFell)   oeSeen <= 1'b1;
    end
  end

  // R10
  page_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACCESS && casEnd && !rasRise) |=> anyPulse);

  // R11
  hidden_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && rasFall && casHeld && prvAny) |=> (state == ST_HIDDEN));

endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
  import dcc_pkg::*;
#(
  parameter int PRE_W      = 8,
  parameter int SELF_LIMIT = 25000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rasN,
  input  logic             caslN,
  input  logic             cashN,
  input  logic             weN,
  input  logic             oeN,
  input  logic [PRE_W-1:0] minPrecharge,
  output logic             evtValid,
  output logic [3:0]       evtCode,
  output logic [1:0]       evtLanes,
  output logic             violation
);

  ctrlStrobe_t      stb;
  busSample_t       curS;
  logic             prvRasN;
  logic [LANES-1:0] prvCasLow;
  logic             selfLong;

  dcc_datapath #(.PRE_W(PRE_W), .SELF_LIMIT(SELF_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN),
    .rasN(rasN), .caslN(caslN), .cashN(cashN), .weN(weN), .oeN(oeN),
    .minPrecharge(minPrecharge), .stb(stb),
    .curS(curS), .prvRasN(prvRasN), .prvCasLow(prvCasLow), .selfLong(selfLong),
    .evtValid(evtValid), .evtCode(evtCode), .evtLanes(evtLanes),
    .violation(violation)
  );

  dcc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .curS(curS), .prvRasN(prvRasN),
    .prvCasLow(prvCasLow), .selfLong(selfLong), .stb(stb)
  );

endmodule

// File: tb/dram_cycle_classifier_test.sv
`timescale 1ns/1ps
module dram_cycle_classifier_test;

  localparam int SELF = 40;

  logic clk = 1'b0, rstN = 1'b0;
  logic rasN = 1'b1, caslN = 1'b1, cashN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [7:0] minPre = 8'd6;
  logic evtValid, violation;
  logic [3:0] evtCode;
  logic [1:0] evtLanes;

  int checks = 0, fails = 0, cyc = 0, riseCyc = 0, wd = 0;
  int expViol = 0, obsViol = 0;
  bit seenRise = 0, lastValid = 0, done = 0;
  logic [5:0] expQ[$];

  always #2 clk = ~clk;

  dram_cycle_classifier #(.PRE_W(8), .SELF_LIMIT(SELF)) uut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .caslN(caslN), .cashN(cashN),
    .weN(weN), .oeN(oeN), .minPrecharge(minPre), .evtValid(evtValid),
    .evtCode(evtCode), .evtLanes(evtLanes), .violation(violation));

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string reqOf(int c);
    case (c)
      1: return "R5"; 2: return "R6"; 3: return "R7"; 4: return "R8";
      5, 6, 7, 8: return "R10";
      9: return "R2"; 10: return "R3"; 11: return "R11"; 12: return "R4";
      default: return "R1";
    endcase
  endfunction

  // R5..R8 single codes 1..4, R10 page codes 5..8
  function automatic int expAccess(int kind, bit pg);
    return (pg ? 5 : 1) + kind;
  endfunction

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); cyc++; end
  endtask

  task automatic push(int code, logic [1:0] ln);
    expQ.push_back({code[3:0], ln});
  endtask

  task automatic setCas(logic [1:0] ln);
    caslN = ~ln[0]; cashN = ~ln[1];
  endtask

  task automatic rasDown();
    bit e;
    e = seenRise && ((cyc - riseCyc) < int'(minPre));
    rasN = 1'b0;
    tick(2);
    if (e) expViol++;
    chk(violation == e, "R12 violation", violation, e);
  endtask

  task automatic rasUp();
    rasN = 1'b1; riseCyc = cyc; seenRise = 1;
  endtask

  task automatic pulse(logic [1:0] ln, int kind, bit pg);
    push(expAccess(kind, pg), ln);
    case (kind)
      0: begin setCas(ln); oeN = 0; tick(3); setCas(0); oeN = 1; tick(2); end
      1: begin weN = 0; tick(1); setCas(ln); tick(2); setCas(0); weN = 1; tick(2); end
      2: begin setCas(ln); tick(1); weN = 0; tick(2); setCas(0); weN = 1; tick(2); end
      default: begin
        setCas(ln); oeN = 0; tick(2); oeN = 1; weN = 0; tick(2);
        setCas(0); weN = 1; tick(2);
      end
    endcase
  endtask

  task automatic accessRas(int n);
    rasDown(); tick(1);
    for (int i = 0; i < n; i++) pulse(2'(1 + $urandom % 3), $urandom % 4, i > 0);
    rasUp();
  endtask

  task automatic rasOnly();
    push(9, 0); rasDown(); tick(2); rasUp();
  endtask

  task automatic cbr(int len);
    setCas(2'b01); tick(2);
    push(len >= SELF ? 12 : 10, 0);
    rasDown(); tick(len - 2); rasUp(); tick(1); setCas(0); tick(1);
  endtask

  task automatic hidden(logic [1:0] ln, int g);
    rasDown(); tick(1);
    setCas(ln); oeN = 0; tick(3);
    push(1, ln); rasUp(); tick(g);
    push(11, 0); rasDown(); tick(2); rasUp(); tick(1);
    setCas(0); oeN = 1; tick(2);
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (violation) obsViol++;
      if (evtValid) begin
        chk(!lastValid, "R13 back-to-back event", 1, 0);
        if (expQ.size() == 0) chk(0, "R1 unexpected event", evtCode, 0);
        else begin
          logic [5:0] e;
          e = expQ.pop_front();
          chk(evtCode == e[5:2], reqOf(e[5:2]), evtCode, e[5:2]);
          chk(evtLanes == e[1:0], "R9 lanes", evtLanes, e[1:0]);
        end
      end
      lastValid = evtValid;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000 && !done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    tick(3); rstN = 1'b1; tick(2);
    chk(evtValid == 0, "R1 reset valid", evtValid, 0);
    chk(violation == 0, "R1 reset violation", violation, 0);
    chk(evtCode == 0, "R1 reset code", evtCode, 0);

    // directed corners
    rasOnly(); tick(8);                       // R2, first fall: R12 no flag
    cbr(5); tick(8);                          // R3
    cbr(SELF - 1); tick(8);                   // R3 just below limit
    cbr(SELF); tick(8);                       // R4 at limit
    rasDown(); tick(1); pulse(2'b11, 0, 0); rasUp(); tick(8);   // R5
    rasDown(); tick(1); pulse(2'b01, 1, 0); rasUp(); tick(8);   // R6
    rasDown(); tick(1); pulse(2'b10, 2, 0); rasUp(); tick(8);   // R7
    rasDown(); tick(1); pulse(2'b11, 3, 0); rasUp(); tick(8);   // R8
    rasDown(); tick(1);                                          // R10
    for (int k = 0; k < 4; k++) pulse(2'b11, k, k > 0);
    rasUp(); tick(8);
    rasDown(); tick(1);                                          // R9 staggered
    push(1, 2'b11);
    caslN = 0; oeN = 0; tick(2); cashN = 0; tick(1); caslN = 1; tick(2);
    cashN = 1; oeN = 1; tick(2); rasUp(); tick(8);
    hidden(2'b10, 7);                                            // R11
    tick(8);
    rasOnly(); tick(2); rasOnly(); tick(6);                      // R12 short, exact
    rasOnly(); tick(5); rasOnly();                               // R12 one below

    // random mix
    for (int i = 0; i < 140; i++) begin
      if (i == 70) minPre = 8'd3;
      tick(1 + $urandom % 9);
      case ($urandom % 5)
        0: rasOnly();
        1: cbr(($urandom % 4 == 0) ? SELF + $urandom % 8 : 3 + $urandom % 30);
        2: hidden(2'(1 + $urandom % 3), 1 + $urandom % 8);
        default: accessRas(1 + $urandom % 4);
      endcase
    end
    tick(10);
    done = 1;
    chk(expQ.size() == 0, "R1 missing events", expQ.size(), 0);
    chk(obsViol == expViol, "R12 violation count", obsViol, expViol);
    summary();
    $finish;
  end

endmodule